// File: doc/BRIEF.md
# Timer Interrupt Entry and Vector Unit

This unit does the processor state work for taking a timer interrupt. When the interrupt controller pulses the take strobe, the unit saves two things. The next-instruction address goes into save/restore register 0. The full machine state word goes into save/restore register 1. The unit then writes back a machine state word in which a fixed group of enable and mode bits is forced low. It also produces the handler fetch address, built from the upper half of a vector prefix register and a slice of the offset register that belongs to the interrupt source. There are two sources: the decrementer and the fixed-interval timer.

A return strobe reverses the entry. Save/restore register 1 is copied back as the machine state word, and save/restore register 0 is sent out as the resume address. Every update lands together on the clock edge after the strobe. A one-cycle redirect-valid pulse comes with the address, and a matching write-enable pulse comes with the new machine state word.

Top module: `irq_entry_unit`

## Requirements
- R1: One cycle after `take_i` is sampled high, `srr0_o` equals the `next_pc_i` value sampled with it.
- R2: One cycle after a take, `srr1_o` equals the full `msr_i` value sampled with it.
- R3: One cycle after a take, these bits of `msr_o` are 0, using bit index 0 as the least significant bit: 26 (cache lock enable for user mode), 25 (vector unit enable), 18 (wait enable), 15 (external enable), 14 (problem state), 13 (floating-point available), 11 and 8 (floating-point exception modes), 5 (instruction address space) and 4 (data address space). Together they form the clear mask 0x0604E930.
- R4: One cycle after a take, every other bit of `msr_o` equals the sampled `msr_i`. This includes critical enable (bit 17), machine check enable (bit 12) and debug enable (bit 9).
- R5: One cycle after a take, `redirect_addr_o` equals the concatenation of `vec_prefix_i` (16 bits, the most significant part), then the selected 12-bit offset field, then four zero bits.
- R6: When `irq_src_i` is 0 (decrementer), the offset field comes from slot 0 of `vec_ofs_i`, bits [11:0]. When it is 1 (fixed-interval timer), it comes from slot 1, bits [23:12].
- R7: `redirect_valid_o` and `msr_we_o` are high together for exactly one cycle after each cycle in which a take or a return is sampled, and are low in every other cycle.
- R8: One cycle after a return (`eret_i` high, `take_i` low), `msr_o` equals the `srr1_o` value held before the edge, and `redirect_addr_o` equals the `srr0_o` value held before the edge.
- R9: When a take and a return are sampled in the same cycle, the take alone is performed.
- R10: `srr0_o` and `srr1_o` change only on a take. A return or an idle cycle leaves them unchanged.
- R11: While `rst` is high, every output is 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Take-interrupt strobe |
| irq_src_i | input | 1 | Interrupt source: 0 decrementer, 1 fixed-interval timer |
| eret_i | input | 1 | Return-from-interrupt strobe |
| next_pc_i | input | 32 | Address of the instruction that would execute next |
| msr_i | input | 32 | Current machine state word |
| vec_prefix_i | input | 16 | Upper half of the vector prefix register |
| vec_ofs_i | input | 24 | Per-source offset fields, 12 bits per slot, slot 0 in the low bits |
| srr0_o | output | 32 | Save/restore register 0 |
| srr1_o | output | 32 | Save/restore register 1 |
| msr_o | output | 32 | Machine state word to write back |
| msr_we_o | output | 1 | Write pulse for `msr_o` |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_addr_o | output | 32 | Handler or resume address |

## Verification
The bound checker looks at every cycle. It checks that the saved registers capture their inputs, that the clear mask leaves the masked bits low and the rest unchanged, that the address has its low nibble at zero, that a return restores the saved state, and that the pulses come only after a strobe. Other behaviour shows up only in the bench's scenarios: the exact prefix and offset concatenation and which offset slot each source uses, take winning over a simultaneous return, and the round trip of several back-to-back takes and returns. The bench checks these against a reference model that holds its own copies of the saved registers.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int MSR_W = 32;

  // Interrupt source codes
  typedef enum logic {
    SRC_DEC = 1'b0,
    SRC_FIT = 1'b1
  } irq_src_e;

  // Bit positions (LSB = 0) forced low on interrupt entry
  localparam int NUM_CLR = 10;
  localparam int CLR_POS [NUM_CLR] = '{26, 25, 18, 15, 14, 13, 11, 8, 5, 4};

  function automatic logic [MSR_W-1:0] entry_clr_mask();
    logic [MSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CLR; i++) m[CLR_POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [MSR_W-1:0] ENTRY_CLR_MASK = entry_clr_mask();

endpackage

// File: rtl/irq_msr_clear.sv
module irq_msr_clear #(
  parameter int W = 32,
  parameter logic [W-1:0] CLR_MASK = '0
) (
  input  logic [W-1:0] msr_in,
  output logic [W-1:0] msr_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (CLR_MASK[b]) begin : g_clr
      assign msr_out[b] = 1'b0;
    end else begin : g_keep
      assign msr_out[b] = msr_in[b];
    end
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int ADDR_W  = 32,
  parameter int PFX_W   = 16,
  parameter int OFS_W   = 12,
  parameter int ALIGN_W = 4,
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [PFX_W-1:0]         prefix,
  input  logic [NUM_SRC*OFS_W-1:0] ofs_tbl,
  input  logic [SEL_W-1:0]         sel,
  output logic [ADDR_W-1:0]        vec_addr
);
  logic [OFS_W-1:0] slot [NUM_SRC];
  logic [OFS_W-1:0] ofs_sel;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    assign slot[s] = ofs_tbl[s*OFS_W +: OFS_W];
  end

  always_comb begin
    ofs_sel = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (sel == SEL_W'(s)) ofs_sel = slot[s];
  end

  assign vec_addr = {prefix, ofs_sel, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PFX_W   = 16,
  parameter int OFS_W   = 12,
  parameter int ALIGN_W = 4,
  parameter int NUM_SRC = 2,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take_i,
  input  logic [SEL_W-1:0]         irq_src_i,
  input  logic                     eret_i,
  input  logic [ADDR_W-1:0]        next_pc_i,
  input  logic [MSR_W-1:0]         msr_i,
  input  logic [PFX_W-1:0]         vec_prefix_i,
  input  logic [NUM_SRC*OFS_W-1:0] vec_ofs_i,
  output logic [ADDR_W-1:0]        srr0_o,
  output logic [MSR_W-1:0]         srr1_o,
  output logic [MSR_W-1:0]         msr_o,
  output logic                     msr_we_o,
  output logic                     redirect_valid_o,
  output logic [ADDR_W-1:0]        redirect_addr_o
);
  logic [MSR_W-1:0]  msr_entry;
  logic [ADDR_W-1:0] vec_addr;
  logic              do_ret;

  irq_msr_clear #(.W(MSR_W), .CLR_MASK(ENTRY_CLR_MASK)) u_clear (
    .msr_in (msr_i),
    .msr_out(msr_entry)
  );

  irq_vector_gen #(
    .ADDR_W(ADDR_W), .PFX_W(PFX_W), .OFS_W(OFS_W),
    .ALIGN_W(ALIGN_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
  ) u_vec (
    .prefix  (vec_prefix_i),
    .ofs_tbl (vec_ofs_i),
    .sel     (irq_src_i),
    .vec_addr(vec_addr)
  );

  assign do_ret = eret_i && !take_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_o           <= '0;
      srr1_o           <= '0;
      msr_o            <= '0;
      msr_we_o         <= 1'b0;
      redirect_valid_o <= 1'b0;
      redirect_addr_o  <= '0;
    end else begin
      msr_we_o         <= take_i || do_ret;
      redirect_valid_o <= take_i || do_ret;
      if (take_i) begin
        srr0_o          <= next_pc_i;
        srr1_o          <= msr_i;
        msr_o           <= msr_entry;
        redirect_addr_o <= vec_addr;
      end else if (do_ret) begin
        msr_o           <= srr1_o;
        redirect_addr_o <= srr0_o;
      end
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              take_i,
  input logic [SEL_W-1:0]  irq_src_i,
  input logic              eret_i,
  input logic [ADDR_W-1:0] next_pc_i,
  input logic [MSR_W-1:0]  msr_i,
  input logic [ADDR_W-1:0] srr0_o,
  input logic [MSR_W-1:0]  srr1_o,
  input logic [MSR_W-1:0]  msr_o,
  input logic              msr_we_o,
  input logic              redirect_valid_o,
  input logic [ADDR_W-1:0] redirect_addr_o
);
  a_r1_srr0_saved: assert property (@(posedge clk) disable iff (rst)
    take_i |=> srr0_o == $past(next_pc_i));

  a_r2_srr1_saved: assert property (@(posedge clk) disable iff (rst)
    take_i |=> srr1_o == $past(msr_i));

  a_r3_bits_cleared: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (msr_o & ENTRY_CLR_MASK) == '0);

  a_r4_bits_kept: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (msr_o & ~ENTRY_CLR_MASK) == ($past(msr_i) & ~ENTRY_CLR_MASK));

  a_r5_vec_aligned: assert property (@(posedge clk) disable iff (rst)
    take_i |=> redirect_addr_o[3:0] == 4'b0000);

  a_r7_pulse_only_after_strobe: assert property (@(posedge clk) disable iff (rst)
    !(take_i || eret_i) |=> !redirect_valid_o && !msr_we_o);

  a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (take_i || eret_i) |=> redirect_valid_o && msr_we_o);

  a_r8_return_restore: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !take_i) |=> msr_o == $past(srr1_o) && redirect_addr_o == $past(srr0_o));

  a_r10_srr_hold: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(srr0_o) && $stable(srr1_o));
endmodule

bind irq_entry_unit irq_entry_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .take_i(take_i), .irq_src_i(irq_src_i), .eret_i(eret_i),
  .next_pc_i(next_pc_i), .msr_i(msr_i), .srr0_o(srr0_o), .srr1_o(srr1_o),
  .msr_o(msr_o), .msr_we_o(msr_we_o), .redirect_valid_o(redirect_valid_o),
  .redirect_addr_o(redirect_addr_o)
);

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;
  localparam logic [31:0] CLR = 32'h0604_E930;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_i = 1'b0, eret_i = 1'b0;
  logic [0:0]  irq_src_i = '0;
  logic [31:0] next_pc_i = '0, msr_i = '0;
  logic [15:0] vec_prefix_i = '0;
  logic [23:0] vec_ofs_i = '0;
  logic [31:0] srr0_o, srr1_o, msr_o, redirect_addr_o;
  logic        msr_we_o, redirect_valid_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] srr0, srr1, msr, addr;
    bit          is_take;
  } exp_t;
  exp_t q[$];
  logic [31:0] m_srr0 = '0, m_srr1 = '0;

  always #5 clk = ~clk;

  irq_entry_unit dut_i (
    .clk(clk), .rst(rst), .take_i(take_i), .irq_src_i(irq_src_i), .eret_i(eret_i),
    .next_pc_i(next_pc_i), .msr_i(msr_i), .vec_prefix_i(vec_prefix_i),
    .vec_ofs_i(vec_ofs_i), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o),
    .msr_we_o(msr_we_o), .redirect_valid_o(redirect_valid_o),
    .redirect_addr_o(redirect_addr_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(bit tk, bit rt, bit src, logic [31:0] pc, logic [31:0] msr,
                       logic [15:0] pfx, logic [23:0] ofs);
    exp_t e;
    logic [11:0] o;
    @(negedge clk); #1;
    take_i = tk; eret_i = rt; irq_src_i = src; next_pc_i = pc; msr_i = msr;
    vec_prefix_i = pfx; vec_ofs_i = ofs;
    o = src ? ofs[23:12] : ofs[11:0];
    if (tk) begin
      m_srr0 = pc; m_srr1 = msr;
      e.srr0 = pc; e.srr1 = msr; e.msr = msr & ~CLR;
      e.addr = {pfx, o, 4'b0000}; e.is_take = 1'b1;
      q.push_back(e);
    end else if (rt) begin
      e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_srr1;
      e.addr = m_srr0; e.is_take = 1'b0;
      q.push_back(e);
    end
    @(negedge clk); #1;
    take_i = 1'b0; eret_i = 1'b0;
  endtask

  // Monitor: compares outputs with the queue head when a pulse appears
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 msr_we matches redirect_valid", {31'b0, msr_we_o}, {31'b0, redirect_valid_o});
      if (redirect_valid_o) begin
        if (q.size() == 0) begin
          chk("R7 unexpected pulse", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_take) begin
            chk("R1 srr0", srr0_o, e.srr0);
            chk("R2 srr1", srr1_o, e.srr1);
            chk("R3 cleared bits", msr_o & CLR, 32'h0);
            chk("R4 kept bits", msr_o & ~CLR, e.msr & ~CLR);
            chk("R5 R6 vector address", redirect_addr_o, e.addr);
          end else begin
            chk("R8 restored msr", msr_o, e.msr);
            chk("R8 resume address", redirect_addr_o, e.addr);
            chk("R10 srr0 held", srr0_o, e.srr0);
            chk("R10 srr1 held", srr1_o, e.srr1);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 srr0", srr0_o, 0);
    chk("R11 srr1", srr1_o, 0);
    chk("R11 msr", msr_o, 0);
    chk("R11 addr", redirect_addr_o, 0);
    chk("R11 pulses", {30'b0, msr_we_o, redirect_valid_o}, 0);
    @(negedge clk); #1; rst = 1'b0;

    // Decrementer and fixed-interval timer with all-ones state
    drive(1, 0, 0, 32'h0000_1234, 32'hFFFF_FFFF, 16'hABCD, 24'h5A5_3C3);
    drive(1, 0, 1, 32'h0000_1238, 32'hFFFF_FFFF, 16'hABCD, 24'h5A5_3C3);
    // Alternating patterns, then return
    drive(1, 0, 0, 32'hDEAD_BEE0, 32'hAAAA_AAAA, 16'h0001, 24'hFFF_000);
    drive(0, 1, 0, 32'h0, 32'h0, 16'h0, 24'h0);
    drive(1, 0, 1, 32'h8000_0004, 32'h5555_5555, 16'hFFFF, 24'h000_FFF);
    drive(0, 1, 1, 32'h1111_1111, 32'h2222_2222, 16'h3333, 24'h444_444);
    // R9: take and return together
    drive(1, 1, 0, 32'hCAFE_0010, 32'h0000_0000, 16'h1234, 24'h876_543);
    // R10: idle cycles leave the saved registers alone
    repeat (3) @(negedge clk);
    chk("R10 idle srr0", srr0_o, 32'hCAFE_0010);
    chk("R10 idle srr1", srr1_o, 32'h0000_0000);

    // Back-to-back random operations
    for (int i = 0; i < 40; i++) begin
      exp_t e;
      logic [11:0] o;
      bit tk, rt, src;
      logic [31:0] pc, ms;
      logic [15:0] pf;
      logic [23:0] of;
      tk = 1'($urandom); rt = 1'($urandom); src = 1'($urandom);
      pc = $urandom; ms = $urandom; pf = 16'($urandom); of = 24'($urandom);
      @(negedge clk); #1;
      take_i = tk; eret_i = rt; irq_src_i = src; next_pc_i = pc; msr_i = ms;
      vec_prefix_i = pf; vec_ofs_i = of;
      o = src ? of[23:12] : of[11:0];
      if (tk) begin
        m_srr0 = pc; m_srr1 = ms;
        e.srr0 = pc; e.srr1 = ms; e.msr = ms & ~CLR;
        e.addr = {pf, o, 4'b0000}; e.is_take = 1'b1;
        q.push_back(e);
      end else if (rt) begin
        e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_srr1;
        e.addr = m_srr0; e.is_take = 1'b0;
        q.push_back(e);
      end
    end
    @(negedge clk); #1; take_i = 1'b0; eret_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 every strobe produced a pulse", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule